// File: doc/BRIEF.md
# Wave-Pipelined Path Issue Controller

This block schedules traffic through a single combinational critical path that has no registers inside it. Several data waves may travel through the path at once. The controller decides when a new input word may be launched into the path. It also decides the exact cycle in which the settled result of each wave is sampled, which is S+1 clock edges after launch. Results that land while the consumer is stalling are kept in a small holding buffer. Each word therefore leaves in launch order, without loss or repetition.

Three constants shape the schedule:

- `LAT` (S) is the number of clock periods a wave needs to settle.
- `GAP` (I) is the minimum spacing between launches.
- `COPIES` (M) is the number of duplicated path instances. Successive launches go to these copies in rotation.

The legal combinations are S ≥ I ≥ 1 and S ≥ M ≥ 1, and at least one of I and M must equal 1. A configuration outside these rules stops elaboration with an error.

Inside the block, a behavioural stand-in for the path applies an identity function. It holds every launched wave until that wave's own sampling cycle, so a result sampled in the wrong cycle is the wrong word. Both edges of the block use a valid/ready handshake. The input side may stall for two reasons: the spacing rule, or not enough buffer room left for the waves already in flight.

Top module: `wave_issue_ctrl`

## Requirements
- R1: A word accepted on clock edge n, with the buffer empty and `out_ready` high, appears on `out_data` with `out_valid` high starting in the cycle after edge n+S+1. That is exactly S+1 edges after acceptance, not earlier and not later.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value. A word is consumed only on an edge where both signals are high, so it is handed over once.
- R3: Two accepted inputs (`in_valid` and `in_ready` high at an edge) are always at least I edges apart.
- R4: When M > 1, successive launches use copies 0, 1, …, M-1 and then wrap to 0. Words launched on back-to-back edges still each emerge exactly S+1 edges after their own launch.
- R5: The sequence of words leaving the block equals the sequence accepted. No word is dropped, duplicated or reordered under any pattern of `in_valid` and `out_ready`.
- R6: The buffer holds D = K+2 words. K is ceil((S+1)/I) when M = 1, and M·ceil((S+1)/M) when M > 1. `in_ready` is low whenever buffered plus in-flight words reach D. Starting empty with `out_ready` held low, exactly D words are accepted.
- R7: With `out_ready` held high and `in_valid` held high from an idle state, a word is accepted every I edges: one per cycle when I = 1.
- R8: A synchronous active-high `rst` clears in-flight waves, the spacing count, the copy rotation and the buffer. After reset, `out_valid` is low and `in_ready` is high, and no word accepted before the reset ever appears at the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream offers a word |
| in_ready | output | 1 | Block will accept the offered word at the next edge |
| in_data | input | DATA_W | Word to launch into the path |
| out_valid | output | 1 | A settled result is presented |
| out_ready | input | 1 | Downstream takes the presented result at the next edge |
| out_data | output | DATA_W | Oldest settled result |

## Verification
Several properties are checked on every cycle:

- the launch spacing;
- the copy rotation;
- the budget that keeps buffered plus in-flight words within D, and the rule that no landing wave finds the buffer full;
- the hold of a stalled output word;
- the cleared state after reset.

Some behaviours can only be shown by the bench's scenarios, which sweep three configurations:

- the exact S+1 landing cycle of each wave;
- word identity and order under random stalls;
- the full-rate spacing of accepts;
- the exact count of D words taken while blocked;
- the disappearance of waves cut off by a reset.

// File: rtl/wpic_pkg.sv
package wpic_pkg;

    // Copy indices travel in a fixed-width field so tags share one type.
    localparam int COPY_IDX_W = 8;

    typedef logic [COPY_IDX_W-1:0] copy_idx_t;

    // One wave in flight: whether the slot is live and which copy carries it.
    typedef struct packed {
        logic      live;
        copy_idx_t copy;
    } wave_tag_t;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Number of waves that can be outstanding at once.
    function automatic int wave_slots(input int lat, input int gap, input int copies);
        if (copies > 1)
            return copies * ceil_div(lat + 1, copies);
        return ceil_div(lat + 1, gap);
    endfunction

    // Holding buffer: outstanding waves plus one draining head plus one launch margin.
    function automatic int hold_depth(input int lat, input int gap, input int copies);
        return wave_slots(lat, gap, copies) + 2;
    endfunction

    // Bits needed to count from 0 to max_val inclusive.
    function automatic int count_w(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

    function automatic bit cfg_ok(input int lat, input int gap, input int copies);
        return (gap >= 1) && (copies >= 1) && (lat >= gap) && (lat >= copies)
            && ((gap == 1) || (copies == 1)) && (copies <= (1 << COPY_IDX_W));
    endfunction

endpackage

// File: rtl/wpic_launch_gate.sv
module wpic_launch_gate
    import wpic_pkg::*;
#(
    parameter int GAP    = 1,
    parameter int COPIES = 1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  logic      room,
    output logic      in_ready,
    output logic      launch,
    output copy_idx_t launch_copy
);

    localparam int GAP_W = count_w(GAP);

    logic spaced;

    generate
        if (GAP > 1) begin : g_spacing
            logic [GAP_W-1:0] wait_q;
            always_ff @(posedge clk) begin
                if (rst)
                    wait_q <= '0;
                else if (launch)
                    wait_q <= GAP_W'(GAP - 1);
                else if (wait_q != '0)
                    wait_q <= wait_q - GAP_W'(1);
            end
            assign spaced = (wait_q == '0);
        end else begin : g_every_cycle
            assign spaced = 1'b1;
        end
    endgenerate

    assign in_ready = spaced && room;
    assign launch   = in_valid && in_ready;

    generate
        if (COPIES > 1) begin : g_rotate
            copy_idx_t next_q;
            always_ff @(posedge clk) begin
                if (rst)
                    next_q <= '0;
                else if (launch)
                    next_q <= (next_q == copy_idx_t'(COPIES - 1)) ? '0 : next_q + copy_idx_t'(1);
            end
            assign launch_copy = next_q;
        end else begin : g_single
            assign launch_copy = '0;
        end
    endgenerate

endmodule

// File: rtl/wpic_wave_path.sv
module wpic_wave_path
    import wpic_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LAT    = 5,
    parameter int COPIES = 1
) (
    input  logic              clk,
    input  logic              launch,
    input  copy_idx_t         launch_copy,
    input  logic [DATA_W-1:0] launch_data,
    input  copy_idx_t         sample_copy,
    output logic [DATA_W-1:0] settled
);

    typedef logic [DATA_W-1:0] word_t;

    word_t copy_out [COPIES];

    // Each copy: a launch register feeding an identity path. The stages that
    // follow stand in for propagation, so the far end shows the wave launched
    // exactly LAT edges before; any other cycle shows a different wave.
    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        word_t front_q;
        word_t wave_q [LAT];

        always_ff @(posedge clk) begin
            if (launch && (launch_copy == copy_idx_t'(c)))
                front_q <= launch_data;
            wave_q[0] <= front_q;
            for (int k = 1; k < LAT; k++)
                wave_q[k] <= wave_q[k-1];
        end

        assign copy_out[c] = wave_q[LAT-1];
    end

    always_comb begin
        settled = copy_out[0];
        for (int c = 1; c < COPIES; c++)
            if (sample_copy == copy_idx_t'(c))
                settled = copy_out[c];
    end

endmodule

// File: rtl/wpic_tag_line.sv
module wpic_tag_line
    import wpic_pkg::*;
#(
    parameter int LAT = 5
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           launch,
    input  copy_idx_t                      launch_copy,
    output logic                           land,
    output copy_idx_t                      land_copy,
    output logic [count_w(LAT + 1)-1:0]    inflight
);

    localparam int STAGES = LAT + 1;
    localparam int FLY_W  = count_w(STAGES);

    wave_tag_t        line_q [STAGES];
    logic [FLY_W-1:0] fly_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++)
                line_q[k] <= '0;
        end else begin
            line_q[0] <= '{live: launch, copy: launch_copy};
            for (int k = 1; k < STAGES; k++)
                line_q[k] <= line_q[k-1];
        end
    end

    // Last stage live: the wave has settled and is sampled at the coming edge.
    assign land      = line_q[LAT].live;
    assign land_copy = line_q[LAT].copy;

    always_ff @(posedge clk) begin
        if (rst)
            fly_q <= '0;
        else
            fly_q <= fly_q + FLY_W'(launch) - FLY_W'(land);
    end

    assign inflight = fly_q;

endmodule

// File: rtl/wpic_hold_fifo.sv
module wpic_hold_fifo
    import wpic_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [DATA_W-1:0]          push_data,
    input  logic                       out_ready,
    output logic                       out_valid,
    output logic [DATA_W-1:0]          out_data,
    output logic [count_w(DEPTH)-1:0]  fill
);

    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int FILL_W = count_w(DEPTH);

    logic [DATA_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0]  rd_q, wr_q;
    logic [FILL_W-1:0] fill_q;
    logic              pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign out_valid = (fill_q != '0);
    assign out_data  = slot_q[rd_q];
    assign pop       = out_valid && out_ready;
    assign fill      = fill_q;

    always_ff @(posedge clk) begin
        if (push)
            slot_q[wr_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q   <= '0;
            wr_q   <= '0;
            fill_q <= '0;
        end else begin
            if (push)
                wr_q <= bump(wr_q);
            if (pop)
                rd_q <= bump(rd_q);
            fill_q <= fill_q + FILL_W'(push) - FILL_W'(pop);
        end
    end

endmodule

// File: rtl/wave_issue_ctrl.sv
module wave_issue_ctrl
    import wpic_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LAT    = 5,
    parameter int GAP    = 1,
    parameter int COPIES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);

    localparam int HOLD_DEPTH = hold_depth(LAT, GAP, COPIES);
    localparam int FILL_W     = count_w(HOLD_DEPTH);
    localparam int FLY_W      = count_w(LAT + 1);
    localparam int OCC_W      = count_w(HOLD_DEPTH + LAT + 1);

    if (!cfg_ok(LAT, GAP, COPIES)) begin : g_bad_cfg
        $error("wave_issue_ctrl: illegal LAT/GAP/COPIES combination");
    end

    logic              launch;
    copy_idx_t         launch_copy;
    logic              land;
    copy_idx_t         land_copy;
    logic [DATA_W-1:0] settled;
    logic [FILL_W-1:0] fill_cnt;
    logic [FLY_W-1:0]  inflight_cnt;
    logic              room;

    // Launch only if every wave already committed still finds a slot.
    assign room = (OCC_W'(fill_cnt) + OCC_W'(inflight_cnt)) < OCC_W'(HOLD_DEPTH);

    wpic_launch_gate #(
        .GAP    (GAP),
        .COPIES (COPIES)
    ) u_gate (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .room        (room),
        .in_ready    (in_ready),
        .launch      (launch),
        .launch_copy (launch_copy)
    );

    wpic_wave_path #(
        .DATA_W (DATA_W),
        .LAT    (LAT),
        .COPIES (COPIES)
    ) u_path (
        .clk         (clk),
        .launch      (launch),
        .launch_copy (launch_copy),
        .launch_data (in_data),
        .sample_copy (land_copy),
        .settled     (settled)
    );

    wpic_tag_line #(
        .LAT (LAT)
    ) u_tags (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .launch_copy (launch_copy),
        .land        (land),
        .land_copy   (land_copy),
        .inflight    (inflight_cnt)
    );

    wpic_hold_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (HOLD_DEPTH)
    ) u_hold (
        .clk       (clk),
        .rst       (rst),
        .push      (land),
        .push_data (settled),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .fill      (fill_cnt)
    );

endmodule

// File: rtl/wave_issue_ctrl_chk.sv
module wave_issue_ctrl_chk
    import wpic_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LAT    = 5,
    parameter int GAP    = 1,
    parameter int COPIES = 3,
    parameter int DEPTH  = 8
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          in_ready,
    input logic                          out_valid,
    input logic                          out_ready,
    input logic [DATA_W-1:0]             out_data,
    input logic                          launch,
    input copy_idx_t                     launch_copy,
    input logic                          land,
    input logic [count_w(DEPTH)-1:0]     fill,
    input logic [count_w(LAT + 1)-1:0]   inflight
);

    localparam int SINCE_W = count_w(GAP);

    logic [SINCE_W-1:0] since_q;
    logic               seen_q;
    copy_idx_t          last_copy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q     <= '0;
            seen_q      <= 1'b0;
            last_copy_q <= '0;
        end else if (launch) begin
            since_q     <= SINCE_W'(1);
            seen_q      <= 1'b1;
            last_copy_q <= launch_copy;
        end else if (int'(since_q) < GAP) begin
            since_q <= since_q + SINCE_W'(1);
        end
    end

    // R3: launches keep the minimum spacing
    a_r3_spacing: assert property (@(posedge clk) disable iff (rst)
        launch && seen_q |-> int'(since_q) >= GAP);

    // R6: committed words never exceed the buffer
    a_r6_budget: assert property (@(posedge clk) disable iff (rst)
        int'(fill) + int'(inflight) <= DEPTH);

    // R6: input stalls once the budget is used up
    a_r6_full_blocks: assert property (@(posedge clk) disable iff (rst)
        int'(fill) + int'(inflight) >= DEPTH |-> !in_ready);

    // R6: a landing wave always finds a free slot
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        land && !(out_valid && out_ready) |-> int'(fill) < DEPTH);

    // R1: a wave only lands while it is counted in flight
    a_r1_land_counted: assert property (@(posedge clk) disable iff (rst)
        land |-> inflight != '0);

    // R2: a stalled output word is held
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R8: reset leaves nothing buffered or in flight
    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> !out_valid && inflight == '0 && fill == '0);

    generate
        if (COPIES > 1) begin : g_rot
            // R4: copies are used in turn
            a_r4_rotate: assert property (@(posedge clk) disable iff (rst)
                launch && seen_q |-> launch_copy ==
                    ((last_copy_q == copy_idx_t'(COPIES - 1)) ? copy_idx_t'(0)
                                                               : last_copy_q + copy_idx_t'(1)));
        end
    endgenerate

endmodule

bind wave_issue_ctrl wave_issue_ctrl_chk #(
    .DATA_W (DATA_W),
    .LAT    (LAT),
    .GAP    (GAP),
    .COPIES (COPIES),
    .DEPTH  (HOLD_DEPTH)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .launch      (launch),
    .launch_copy (launch_copy),
    .land        (land),
    .fill        (fill_cnt),
    .inflight    (inflight_cnt)
);

// File: tb/wave_issue_ctrl_lane.sv
module wave_issue_ctrl_lane #(
    parameter int LAT    = 5,
    parameter int GAP    = 1,
    parameter int COPIES = 1,
    parameter int SEED   = 1
) (
    input  logic clk,
    output int   errs,
    output int   chks,
    output logic done
);

    localparam int W     = 16;
    localparam int SLOTS = (COPIES > 1) ? COPIES * ((LAT + COPIES) / COPIES) : (LAT + GAP) / GAP;
    localparam int CAP   = SLOTS + 2;

    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic [W-1:0] in_data;
    logic         out_valid;
    logic         out_ready;
    logic [W-1:0] out_data;

    wave_issue_ctrl #(
        .DATA_W (W),
        .LAT    (LAT),
        .GAP    (GAP),
        .COPIES (COPIES)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    logic [W-1:0] exp_q [$];
    logic [W-1:0] pend_w [$];
    int           pend_due [$];
    int           edge_n;
    int           last_acc;
    logic [W-1:0] word_ctr;

    function automatic void fail(input string req, input string what, input int act, input int exp);
        errs++;
        $display("FAIL %s lane(S=%0d,I=%0d,M=%0d) %s: actual=%0d expected=%0d",
                 req, LAT, GAP, COPIES, what, act, exp);
    endfunction

    // One clock: drive, record handshakes, step the model, compare after the edge.
    task automatic tick(input logic iv, input logic ordy, input logic r, input string req,
                        output logic took);
        logic         pop;
        logic         blocked;
        logic         exp_v;
        logic [W-1:0] held;
        rst       = r;
        in_valid  = iv;
        out_ready = ordy;
        in_data   = word_ctr;
        #1;
        took    = iv && !r && (in_ready === 1'b1);
        pop     = !r && (out_valid === 1'b1) && ordy;
        blocked = !r && (out_valid === 1'b1) && !ordy;
        held    = out_data;
        if (took) begin
            chks++;
            if (edge_n + 1 - last_acc < GAP)
                fail("R3", "accept spacing", edge_n + 1 - last_acc, GAP);
            last_acc = edge_n + 1;
            pend_w.push_back(word_ctr);
            pend_due.push_back(edge_n + 1 + LAT + 1);
            word_ctr = word_ctr + 16'd1;
        end
        @(posedge clk);
        edge_n++;
        if (r) begin
            exp_q.delete();
            pend_w.delete();
            pend_due.delete();
            last_acc = -1000;
        end else begin
            if (pop)
                void'(exp_q.pop_front());
            while (pend_due.size() > 0 && pend_due[0] == edge_n) begin
                exp_q.push_back(pend_w.pop_front());
                void'(pend_due.pop_front());
            end
        end
        @(negedge clk);
        chks++;
        exp_v = (exp_q.size() > 0);
        if (out_valid !== exp_v)
            fail(req, "out_valid", int'(out_valid), int'(exp_v));
        else if (exp_v && out_data !== exp_q[0])
            fail(req, "out_data", int'(out_data), int'(exp_q[0]));
        if (blocked) begin
            chks++;
            if (out_valid !== 1'b1 || out_data !== held)
                fail("R2", "stalled word held", int'(out_data), int'(held));
        end
    endtask

    initial begin
        logic t;
        int   n;
        int   acc_n;
        errs      = 0;
        chks      = 0;
        done      = 1'b0;
        edge_n    = 0;
        last_acc  = -1000;
        word_ctr  = W'(SEED * 4096);
        rst       = 1'b1;
        in_valid  = 1'b0;
        out_ready = 1'b1;
        in_data   = '0;
        void'($urandom(SEED));
        @(negedge clk);

        // R8: reset state
        repeat (3) tick(1'b0, 1'b1, 1'b1, "R8", t);
        chks++;
        if (in_ready !== 1'b1) fail("R8", "in_ready after reset", int'(in_ready), 1);
        chks++;
        if (out_valid !== 1'b0) fail("R8", "out_valid after reset", int'(out_valid), 0);

        // R1: exact landing cycle of a lone word
        tick(1'b1, 1'b1, 1'b0, "R1", t);
        n = 0;
        while (out_valid !== 1'b1 && n < LAT + 6) begin
            tick(1'b0, 1'b1, 1'b0, "R1", t);
            n++;
        end
        chks++;
        if (n != LAT + 1) fail("R1", "edges from accept to out_valid", n, LAT + 1);
        tick(1'b0, 1'b1, 1'b0, "R2", t);
        chks++;
        if (out_valid !== 1'b0) fail("R2", "word presented once", int'(out_valid), 0);

        // R7 (and R4 with several copies): full-rate stream
        acc_n = 0;
        for (int i = 0; i < 6 * GAP; i++) begin
            tick(1'b1, 1'b1, 1'b0, (COPIES > 1) ? "R4" : "R1", t);
            acc_n += int'(t);
        end
        chks++;
        if (acc_n != 6) fail("R7", "accepts in stream window", acc_n, 6);
        repeat (LAT + 4) tick(1'b0, 1'b1, 1'b0, "R5", t);

        // R6: blocked output, buffer fills to capacity
        acc_n = 0;
        repeat (CAP * GAP + LAT + 8) begin
            tick(1'b1, 1'b0, 1'b0, "R6", t);
            acc_n += int'(t);
        end
        chks++;
        if (acc_n != CAP) fail("R6", "words accepted while blocked", acc_n, CAP);
        chks++;
        if (in_ready !== 1'b0) fail("R6", "in_ready at capacity", int'(in_ready), 0);
        repeat (CAP + LAT + 4) tick(1'b0, 1'b1, 1'b0, "R6", t);

        // R5: random traffic with random backpressure
        repeat (400) begin
            tick(($urandom % 10) < 7, ($urandom % 2) == 1, 1'b0, "R5", t);
        end
        repeat (CAP + LAT + 6) tick(1'b0, 1'b1, 1'b0, "R5", t);

        // R8: reset with waves in flight and words buffered
        repeat (3) tick(1'b1, 1'b0, 1'b0, "R5", t);
        repeat (2) tick(1'b0, 1'b1, 1'b1, "R8", t);
        repeat (LAT + 4) tick(1'b0, 1'b1, 1'b0, "R8", t);
        chks++;
        if (in_ready !== 1'b1) fail("R8", "in_ready after mid-run reset", int'(in_ready), 1);

        // R5: traffic resumes cleanly
        repeat (4 * GAP) tick(1'b1, 1'b1, 1'b0, "R5", t);
        repeat (LAT + 4) tick(1'b0, 1'b1, 1'b0, "R5", t);
        chks++;
        if (exp_q.size() != 0 || pend_w.size() != 0)
            fail("R5", "words left undelivered", exp_q.size() + pend_w.size(), 0);

        done = 1'b1;
    end

endmodule

// File: tb/wave_issue_ctrl_test.sv
`timescale 1ns/1ps
module wave_issue_ctrl_test;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    int   e_a, c_a, e_b, c_b, e_c, c_c;
    logic d_a, d_b, d_c;

    // Spaced launches on one copy
    wave_issue_ctrl_lane #(.LAT(5), .GAP(3), .COPIES(1), .SEED(1)) lane_a (
        .clk(clk), .errs(e_a), .chks(c_a), .done(d_a));

    // Every-cycle launches rotated over three copies
    wave_issue_ctrl_lane #(.LAT(5), .GAP(1), .COPIES(3), .SEED(2)) lane_b (
        .clk(clk), .errs(e_b), .chks(c_b), .done(d_b));

    // Shortest path
    wave_issue_ctrl_lane #(.LAT(1), .GAP(1), .COPIES(1), .SEED(3)) lane_c (
        .clk(clk), .errs(e_c), .chks(c_c), .done(d_c));

    initial begin
        int cycles;
        int errors;
        int total;
        cycles = 0;
        @(negedge clk);
        while (!(d_a === 1'b1 && d_b === 1'b1 && d_c === 1'b1) && cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        @(negedge clk);
        errors = e_a + e_b + e_c;
        total  = c_a + c_b + c_c;
        if (!(d_a === 1'b1 && d_b === 1'b1 && d_c === 1'b1)) begin
            errors++;
            total++;
            $display("FAIL watchdog: lanes finished actual=%0d expected=%0d",
                     int'(d_a === 1'b1) + int'(d_b === 1'b1) + int'(d_c === 1'b1), 3);
        end
        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end

endmodule